// File: doc/BRIEF.md
# Glitch-Free Power-of-Two System Clock Divider

This block derives a system clock from a faster master clock by dividing it by a power of two. A select code picks the exponent. A one-cycle load strobe hands in a new code while the block runs. A free-running counter on the master clock marks the end of every divided period. The output clock is made by gating the master clock with an enable that is captured on the falling master edge, so every output pulse is one whole master high phase. The output never carries a runt pulse or a clipped low phase.

A requested code does not act at once. It waits in a pending register until the period in progress has run to its end. At that output rising edge the counter restarts from zero and the new factor takes over. Each output period is therefore a complete period of either the old factor or the new one, so no period is ever shorter than the smaller of the two. The first new-length period ends no later than one old period plus one new period after the request.

A clock-enable output serves logic that stays on the master clock. It is high for the single master cycle whose closing rising edge is also a rising edge of the divided clock.

Top module: `sysclk_prescaler`

## Requirements
- R1: The division factor is 2 to the power of the active code, for codes 0 to 8. The time between consecutive rising edges of `sys_clk_o` is exactly that many master periods. Code 0 passes the master clock through, code 3 divides by 8 and code 8 divides by 256.
- R2: Each high phase of `sys_clk_o` starts on a master rising edge and lasts exactly half a master period. The output stays low for the rest of the divided period.
- R3: The active code after reset is the parameter `RESET_CODE`, which defaults to 3. The first rising edge of `sys_clk_o` falls on the 2^RESET_CODE-th master rising edge after reset is released.
- R4: A code loaded mid-period leaves the period in progress at its old length. The new factor governs every period that starts at or after the next rising edge of `sys_clk_o`.
- R5: Select codes 9 to 15 are treated exactly as code 8, which divides by 256.
- R6: A strobe in the master cycle that ends on an output rising edge takes effect at that edge. When several strobes fall within one period, the last one decides the next factor.
- R7: `sys_ce_o` is high for exactly the master cycles whose closing rising edge is a rising edge of `sys_clk_o`, and is low in every other cycle.
- R8: While `arst_ni` is low, `sys_clk_o` is low. With the default reset code, `sys_ce_o` is also low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Undivided master clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | SEL_W | Requested exponent code |
| div_load_i | input | 1 | One-cycle strobe that captures `div_sel_i` |
| sys_clk_o | output | 1 | Divided, glitch-free system clock |
| sys_ce_o | output | 1 | Master-domain enable marking each divided rising edge |

## Verification
A counter or code register holding a wrong value shows at the ports no later than the next rising edge of `sys_clk_o`. That edge arrives early or late against the factor the bench expects, and `sys_ce_o` disagrees with the divided edge in the same cycle. A pending code that is lost or applied too early shows on the first output period after the strobe as a wrong period length. A flaw in the gating stage shows as a high phase that is not exactly half a master period. The bench sweeps every pair of small codes with a strobe at every phase of the old period. It also visits all sixteen codes and measures every high phase and every period.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;

  // Limit a requested exponent to the largest supported one.
  function automatic int unsigned clamp_code(input int unsigned code,
                                             input int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // Low-order ones mask whose all-ones value marks the last count of a period.
  function automatic logic [31:0] code_mask(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/psc_code_ctrl.sv
`timescale 1ns/1ps
module psc_code_ctrl #(
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned MAX_CODE   = 8,
  parameter int unsigned RESET_CODE = 3
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              load_i,
  input  logic              wrap_i,
  output logic [CODE_W-1:0] cur_code_o
);

  logic [CODE_W-1:0] req_code;
  logic [CODE_W-1:0] pend_q;
  logic [CODE_W-1:0] cur_q;
  logic [CODE_W-1:0] want_code;

  assign req_code  = CODE_W'(psc_pkg::clamp_code(32'(sel_i), MAX_CODE));
  assign want_code = load_i ? req_code : pend_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      pend_q <= CODE_W'(RESET_CODE);
      cur_q  <= CODE_W'(RESET_CODE);
    end else begin
      if (load_i) pend_q <= req_code;
      if (wrap_i) cur_q  <= want_code;
    end
  end

  assign cur_code_o = cur_q;

  // R4: the active code only moves at a period boundary
  a_r4_hold_mid_period: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !wrap_i |=> $stable(cur_q));

  // R5: reserved codes never reach the counter
  a_r5_code_in_range: assert property (@(posedge clk_i) disable iff (!arst_ni)
    32'(cur_q) <= MAX_CODE);

  // R6: a strobe coinciding with the boundary is adopted there
  a_r6_same_cycle_load: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (load_i && wrap_i) |=> (32'(cur_q) == psc_pkg::clamp_code(32'($past(sel_i)), MAX_CODE)));

endmodule

// File: rtl/psc_div_cnt.sv
`timescale 1ns/1ps
module psc_div_cnt #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_mask;

  assign last_mask = CNT_W'(psc_pkg::code_mask(32'(code_i)));
  assign wrap_o    = ((cnt_q & last_mask) == last_mask);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: every new period starts from a zero count
  a_r4_restart_on_wrap: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wrap_o |=> (cnt_q == '0));

  // R1: the count never passes the last value of the active factor
  a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt_q & ~last_mask) == '0);

endmodule

// File: rtl/psc_clk_gate.sv
`timescale 1ns/1ps
module psc_clk_gate (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic en_i,
  output logic clk_o
);

  logic gate_q;

  // Captured while the master clock is low, so the AND below cannot clip a pulse.
  always_ff @(negedge clk_i or negedge arst_ni) begin
    if (!arst_ni) gate_q <= 1'b0;
    else          gate_q <= en_i;
  end

  assign clk_o = clk_i & gate_q;

endmodule

// File: rtl/sysclk_prescaler.sv
`timescale 1ns/1ps
module sysclk_prescaler #(
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned MAX_CODE   = 8,
  parameter int unsigned RESET_CODE = 3
) (
  input  logic             mclk_i,
  input  logic             arst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             div_load_i,
  output logic             sys_clk_o,
  output logic             sys_ce_o
);

  localparam int unsigned CODE_W = $clog2(MAX_CODE + 1);
  localparam int unsigned CNT_W  = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic              period_end;
  logic [CODE_W-1:0] active_code;

  psc_code_ctrl #(
    .SEL_W     (SEL_W),
    .CODE_W    (CODE_W),
    .MAX_CODE  (MAX_CODE),
    .RESET_CODE(RESET_CODE)
  ) u_code (
    .clk_i     (mclk_i),
    .arst_ni   (arst_ni),
    .sel_i     (div_sel_i),
    .load_i    (div_load_i),
    .wrap_i    (period_end),
    .cur_code_o(active_code)
  );

  psc_div_cnt #(
    .CODE_W(CODE_W),
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i  (mclk_i),
    .arst_ni(arst_ni),
    .code_i (active_code),
    .wrap_o (period_end)
  );

  psc_clk_gate u_gate (
    .clk_i  (mclk_i),
    .arst_ni(arst_ni),
    .en_i   (period_end),
    .clk_o  (sys_clk_o)
  );

  assign sys_ce_o = period_end;

  // R7: with a non-zero code the enable never lasts two cycles in a row
  a_r7_single_pulse: assert property (@(posedge mclk_i) disable iff (!arst_ni)
    (period_end && active_code != '0) |=> !(period_end && $stable(active_code)));

endmodule

// File: tb/sysclk_prescaler_tb.sv
`timescale 1ns/1ps
module sysclk_prescaler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  logic       mclk   = 1'b0;
  logic       arst_n = 1'b0;
  logic [3:0] sel    = 4'd0;
  logic       load   = 1'b0;
  logic       sclk;
  logic       ce;

  int  n_chk = 0;
  int  n_err = 0;
  int  act_f = 8;
  int  pend_f = 8;
  time last_rise = 0;
  bit  tracking = 1'b0;
  bit  ce_s = 1'b0;
  bit  done = 1'b0;

  sysclk_prescaler u_dut (
    .mclk_i    (mclk),
    .arst_ni   (arst_n),
    .div_sel_i (sel),
    .div_load_i(load),
    .sys_clk_o (sclk),
    .sys_ce_o  (ce)
  );

  always #(HALF) mclk = ~mclk;

  function automatic int fac(input int code);
    return (code >= 9) ? 256 : (1 << code);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_load(input int code);
    @(negedge mclk);
    sel    = 4'(code);
    load   = 1'b1;
    pend_f = fac(code);
    @(negedge mclk);
    load   = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge sclk);
  endtask

  // R1 / R4 / R6: every period equals the factor adopted at its opening edge
  always @(posedge sclk) begin
    if (tracking) begin
      check(longint'($time - last_rise) == longint'(act_f * CLK_PERIOD), "R1 period",
            longint'($time - last_rise), longint'(act_f * CLK_PERIOD));
      act_f     = pend_f;
      last_rise = $time;
    end
  end

  // R2: high phase is half a master period
  always @(negedge sclk) begin
    if (tracking)
      check(longint'($time - last_rise) == longint'(HALF), "R2 high time",
            longint'($time - last_rise), longint'(HALF));
  end

  // R7: enable sampled before the edge matches the divided edge
  always @(negedge mclk) ce_s = ce;
  always @(posedge mclk) begin
    if (tracking) begin
      #1;
      check(sclk === ce_s, "R7 enable alignment", longint'(sclk), longint'(ce_s));
    end
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    time t0;
    time t_rel;
    repeat (3) @(negedge mclk);
    // R8: reset state
    check(sclk == 1'b0, "R8 clock low in reset", longint'(sclk), 0);
    check(ce == 1'b0, "R8 enable low in reset", longint'(ce), 0);

    @(negedge mclk);
    arst_n    = 1'b1;
    t_rel     = $time;
    last_rise = $time - HALF;
    tracking  = 1'b1;
    // R3: first edge on the eighth master rising edge
    @(posedge sclk);
    check(longint'($time - t_rel) == longint'(7 * CLK_PERIOD + HALF), "R3 first edge",
          longint'($time - t_rel), longint'(7 * CLK_PERIOD + HALF));
    wait_edges(1);

    // Near-exhaustive: every small old/new pair, strobe at every phase
    for (int o = 0; o <= 4; o++) begin
      for (int n = 0; n <= 4; n++) begin
        for (int off = 0; off < fac(o); off++) begin
          do_load(o);
          wait_edges(2);
          repeat (off) @(negedge mclk);
          do_load(n);
          wait_edges(2);
        end
      end
    end

    // R4: long old period completes before a short one starts
    do_load(6);
    wait_edges(2);
    t0 = $time;
    repeat (10) @(negedge mclk);
    do_load(1);
    @(posedge sclk);
    check(longint'($time - t0) == longint'(64 * CLK_PERIOD), "R4 old period kept",
          longint'($time - t0), longint'(64 * CLK_PERIOD));
    t0 = $time;
    @(posedge sclk);
    check(longint'($time - t0) == longint'(2 * CLK_PERIOD), "R4 new period",
          longint'($time - t0), longint'(2 * CLK_PERIOD));

    // R6: last of several strobes within one period wins
    do_load(4);
    wait_edges(2);
    do_load(5);
    do_load(2);
    @(posedge sclk);
    t0 = $time;
    @(posedge sclk);
    check(longint'($time - t0) == longint'(4 * CLK_PERIOD), "R6 last strobe wins",
          longint'($time - t0), longint'(4 * CLK_PERIOD));

    // R5: all sixteen codes, reserved ones behave as divide-by-256
    for (int c = 0; c < 16; c++) begin
      do_load(c);
      wait_edges(2);
      t0 = $time;
      @(posedge sclk);
      check(longint'($time - t0) == longint'(fac(c) * CLK_PERIOD),
            (c >= 9) ? "R5 reserved code" : "R1 code sweep",
            longint'($time - t0), longint'(fac(c) * CLK_PERIOD));
    end

    // Random changes at random phases; monitors check every edge
    for (int k = 0; k < 30; k++) begin
      repeat ($urandom_range(0, 40)) @(negedge mclk);
      do_load($urandom_range(0, 9));
      wait_edges(1);
    end
    wait_edges(2);

    done = 1'b1;
    finish_run();
  end

endmodule